// File: doc/BRIEF.md
# Bit Scatter/Gather Unit

This block moves bits of a 64-bit data word between fixed low-order positions and positions picked at run time by a 64-bit mask. It has two operations. In deposit (scatter), the low-order data bits are taken one after another and placed, in order, into the bit positions where the mask holds a one. In extract (gather), the data bits found under the mask's ones are collected and packed, in order, into the low end of the result.

Both operations share one prefix count of mask ones. For each bit position, this count gives how many mask ones lie strictly below that position. A single-bit opcode selects the operation. The result is captured in a register and marked by a one-cycle valid pulse.

Top module: `bit_scatter_gather`

## Requirements
- R1: While reset (active low) is asserted, and after it is released with no request issued, `out_valid_o` is 0 and `result_o` is all zeros.
- R2: With `op_i` = 0 (deposit), the n-th mask one counted upward from bit 0 (n starting at 0) receives data bit n.
- R3: In deposit, every result bit whose mask bit is 0 is 0.
- R4: With `op_i` = 1 (extract), the data bit under the n-th mask one counted upward from bit 0 appears at result bit n.
- R5: In extract, every result bit at an index equal to or above the number of mask ones is 0.
- R6: A request with `in_valid_i` high at a rising edge yields `out_valid_o` high and the matching result after that same edge. `out_valid_o` is low after every edge at which `in_valid_i` was low.
- R7: While `in_valid_i` is low, `result_o` keeps its last value, whatever the data, mask and opcode inputs do.
- R8: For both operations, an all-zero mask gives a zero result, and an all-ones mask returns the data unchanged.
- R9: Extracting with a mask and then depositing that result with the same mask gives the original data ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 1 | 0 = deposit, 1 = extract |
| data_i | input | 64 | Data word |
| mask_i | input | 64 | Position mask |
| out_valid_o | output | 1 | One-cycle pulse marking a new result |
| result_o | output | 64 | Registered result |

## Verification
The hardest case to reach is a data bit routed to the far end of the word, where the prefix count is at its extremes. One example is a mask with only bit 63 set, which sends data bit 0 to bit 63 in deposit and moves bit 63 down to bit 0 in extract. Another is an all-ones mask, where the count reaches 64. Random masks almost never produce these, so the stimulus lists them explicitly: single high-bit masks, all-zero masks, all-ones masks and alternating masks. These are followed by random words, and by chained extract-then-deposit pairs that check the round trip.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic {
    BSG_DEPOSIT = 1'b0,
    BSG_EXTRACT = 1'b1
  } bsg_op_e;
endpackage

// File: rtl/bsg_prefix_count.sv
// Exclusive running count of mask ones: rank_o[g] = ones in mask_i[g-1:0].
module bsg_prefix_count #(
  parameter int W  = 64,
  parameter int IW = $clog2(W),
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]          mask_i,
  output logic [W-1:0][IW-1:0]  rank_o,
  output logic [CW-1:0]         total_o
);
  logic [W:0][CW-1:0] run;

  assign run[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_chain
    assign run[g+1]  = run[g] + CW'(mask_i[g]);
    // run[g] <= g < W, so it always fits in IW bits
    assign rank_o[g] = run[g][IW-1:0];
  end

  assign total_o = run[W];
endmodule

// File: rtl/bsg_deposit.sv
// Scatter: each selected position pulls the data bit whose index is its rank.
module bsg_deposit #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]          data_i,
  input  logic [W-1:0]          mask_i,
  input  logic [W-1:0][IW-1:0]  rank_i,
  output logic [W-1:0]          word_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign word_o[g] = mask_i[g] & data_i[rank_i[g]];
  end
endmodule

// File: rtl/bsg_extract.sv
// Gather: each selected data bit is written to the result index equal to its rank.
module bsg_extract #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]          data_i,
  input  logic [W-1:0]          mask_i,
  input  logic [W-1:0][IW-1:0]  rank_i,
  output logic [W-1:0]          word_o
);
  always_comb begin
    word_o = '0;
    for (int i = 0; i < W; i++) begin
      if (mask_i[i]) word_o[rank_i[i]] = data_i[i];
    end
  end
endmodule

// File: rtl/bit_scatter_gather.sv
module bit_scatter_gather #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid_i,
  input  logic         op_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic         out_valid_o,
  output logic [W-1:0] result_o
);
  import bsg_pkg::*;

  localparam int IW = $clog2(W);
  localparam int CW = $clog2(W + 1);

  // Internal events named for the checker
  logic [W-1:0][IW-1:0] mask_rank;
  logic [CW-1:0]        mask_total;
  logic [W-1:0]         dep_word;
  logic [W-1:0]         ext_word;
  logic [W-1:0]         sel_word;
  bsg_op_e              op_sel;

  assign op_sel = bsg_op_e'(op_i);

  bsg_prefix_count #(.W(W), .IW(IW), .CW(CW)) u_rank (
    .mask_i  (mask_i),
    .rank_o  (mask_rank),
    .total_o (mask_total)
  );

  bsg_deposit #(.W(W), .IW(IW)) u_dep (
    .data_i (data_i),
    .mask_i (mask_i),
    .rank_i (mask_rank),
    .word_o (dep_word)
  );

  bsg_extract #(.W(W), .IW(IW)) u_ext (
    .data_i (data_i),
    .mask_i (mask_i),
    .rank_i (mask_rank),
    .word_o (ext_word)
  );

  assign sel_word = (op_sel == BSG_EXTRACT) ? ext_word : dep_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= sel_word;
    end
  end
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid_i,
  input logic          op_i,
  input logic [W-1:0]  data_i,
  input logic [W-1:0]  mask_i,
  input logic          out_valid_o,
  input logic [W-1:0]  result_o,
  input logic [CW-1:0] mask_total,
  input logic [W-1:0]  dep_word
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o) else $error("valid pulse missing"); // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o) else $error("spurious valid"); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(result_o)) else $error("result moved while idle"); // R7

  AST_DEP_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !op_i) |=> ((result_o & ~$past(mask_i)) == '0))
    else $error("deposit wrote outside mask"); // R3

  AST_EXT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i) |=> ((result_o >> $countones($past(mask_i))) == '0))
    else $error("extract high bits not clear"); // R5

  AST_FULL_MASK_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && (mask_i == '1)) |=> (result_o == $past(data_i)))
    else $error("all-ones mask altered data"); // R8

  AST_RANK_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mask_total) == $countones(mask_i)) else $error("prefix total wrong"); // R5

  AST_DEP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dep_word) <= 32'(mask_total)) else $error("deposit set too many bits"); // R2
endmodule

bind bit_scatter_gather bsg_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .data_i      (data_i),
  .mask_i      (mask_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .mask_total  (mask_total),
  .dep_word    (dep_word)
);

// File: tb/bit_scatter_gather_tb.sv
`timescale 1ns/1ps
module bit_scatter_gather_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid_i;
  logic        op_i;
  logic [63:0] data_i;
  logic [63:0] mask_i;
  logic        out_valid_o;
  logic [63:0] result_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bit_scatter_gather #(.W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
    .data_i(data_i), .mask_i(mask_i), .out_valid_o(out_valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] ref_dep(logic [63:0] d, logic [63:0] m);
    logic [63:0] r = '0;
    int j = 0;
    for (int i = 0; i < 64; i++) if (m[i]) begin r[i] = d[j]; j++; end
    return r;
  endfunction

  function automatic logic [63:0] ref_ext(logic [63:0] d, logic [63:0] m);
    logic [63:0] r = '0;
    int j = 0;
    for (int i = 0; i < 64; i++) if (m[i]) begin r[j] = d[i]; j++; end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference, compared every clock
  logic        exp_v;
  logic [63:0] exp_r;
  logic        exp_op;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_r <= '0; exp_op <= 1'b0;
    end else begin
      exp_v <= in_valid_i;
      if (in_valid_i) begin
        exp_r  <= op_i ? ref_ext(data_i, mask_i) : ref_dep(data_i, mask_i);
        exp_op <= op_i;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid_o == exp_v, "R6", 64'(out_valid_o), 64'(exp_v));
      chk(result_o == exp_r, exp_v ? (exp_op ? "R4" : "R2") : "R7", result_o, exp_r);
    end
  end

  logic [63:0] last;
  task automatic run(logic op, logic [63:0] d, logic [63:0] m);
    @(negedge clk);
    op_i = op; data_i = d; mask_i = m; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    last = result_o;
    chk(out_valid_o === 1'b1, "R6", 64'(out_valid_o), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid_i = 1'b0; op_i = 1'b0; data_i = '0; mask_i = '0;
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b0 && result_o == '0, "R1", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0 && result_o == '0, "R1", result_o, 64'd0);

    // R2/R4: far-end routing
    run(1'b0, 64'h1, 64'h8000_0000_0000_0000);
    chk(last == 64'h8000_0000_0000_0000, "R2", last, 64'h8000_0000_0000_0000);
    run(1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    chk(last == 64'h1, "R4", last, 64'h1);
    run(1'b0, 64'h0000_0000_0000_000B, 64'hF000_0000_0000_0000);
    chk(last == 64'hB000_0000_0000_0000, "R2", last, 64'hB000_0000_0000_0000);
    run(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA);
    chk(last == 64'h0000_0000_FFFF_FFFF, "R4", last, 64'h0000_0000_FFFF_FFFF);

    // R8: zero and full masks
    for (int op = 0; op < 2; op++) begin
      run(op[0], 64'hDEAD_BEEF_0123_4567, '0);
      chk(last == '0, "R8", last, 64'd0);
      run(op[0], 64'hDEAD_BEEF_0123_4567, '1);
      chk(last == 64'hDEAD_BEEF_0123_4567, "R8", last, 64'hDEAD_BEEF_0123_4567);
    end

    // Random patterns, R3 and R5 checked explicitly
    for (int n = 0; n < 40; n++) begin
      logic [63:0] d, m;
      d = {$urandom, $urandom};
      m = {$urandom, $urandom};
      if (n % 4 == 1) m = m & {$urandom, $urandom};
      run(1'b0, d, m);
      chk((last & ~m) == '0, "R3", last & ~m, 64'd0);
      run(1'b1, d, m);
      chk((last >> $countones(m)) == '0, "R5", last, ref_ext(d, m));
    end

    // R7: idle with moving inputs
    run(1'b1, 64'h0123_4567_89AB_CDEF, 64'h00FF_00FF_00FF_00FF);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      op_i = n[0]; data_i = {$urandom, $urandom}; mask_i = {$urandom, $urandom};
      chk(result_o == last, "R7", result_o, last);
    end

    // R9: extract then deposit with the same mask
    for (int n = 0; n < 12; n++) begin
      logic [63:0] d, m;
      d = {$urandom, $urandom};
      m = {$urandom, $urandom};
      run(1'b1, d, m);
      run(1'b0, last, m);
      chk(last == (d & m), "R9", last, d & m);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule